// File: doc/BRIEF.md
# Reset Source Controller with Clock-Loss Watchdog

This block merges the reset requests of a small system into one synchronous system reset. There are three request sources: an active-low external reset pin, a supply-monitor comparator that reports whether the supply is above its threshold, and a missing-clock detector. The detector watches the system clock from a free-running reference clock. The whole controller runs in the reference clock domain. Its own state is cleared only by the power-on reset input, so it keeps its configuration and its cause record across the system resets it generates.

A single reset event is counted from the first active request until the last request drops. When an event starts, the controller records one cause flag: the highest-priority source that is active at that edge. Software reads the cause through a byte-wide register bus. The same bus sets the configuration. The supply monitor has an enable bit in its control register and a separate select bit in the source register, and both must be set before it can reset the system. The clock detector is switched on and off by writing bit 2 of the source register. When read, that same bit reports whether the last reset came from a lost clock.

Top module: `reset_src_ctrl`

## Requirements
- R1: While `por_n` is low, `sys_rst` is high, all configuration bits are 0 and all cause flags are 0. After `por_n` rises, `sys_rst` stays high for at least STRETCH_CYC reference cycles and then falls.
- R2: Driving `ext_rst_n` low asserts `sys_rst`. After that reset, bit 0 of the source register (address SRC_ADDR, default 0xEF) reads 1.
- R3: With the detector enabled, if `sys_clk` stays low, or stays high, for more than TIMEOUT_CYC reference cycles, `sys_rst` is asserted. After that reset, bit 2 of the source register reads 1.
- R4: After a reset whose cause is the external pin or the supply monitor, bit 2 of the source register reads 0.
- R5: Writing bit 2 of the source register enables the detector when the bit is 1 and disables it when the bit is 0. While the detector is disabled, a stopped `sys_clk` never asserts `sys_rst`.
- R6: The supply control register sits at address 0xFF. Bit 7 is the monitor enable and is read/write. Bit 6 is read-only and shows the synchronized comparator: 1 means the supply is above threshold, 0 means it is at or below threshold. Bits 5:0 always read 0 and ignore writes.
- R7: The supply monitor asserts `sys_rst` only when the comparator is low and both the enable (bit 7 at 0xFF) and the select (bit 1 of the source register, write side) are 1. After a supply reset, bit 1 of the source register reads 1.
- R8: When several sources start a reset together, exactly one cause flag is set. The pin wins over the supply monitor, and the supply monitor wins over the clock detector.
- R9: The cause flags are captured only at the edge where a reset event starts. A source that becomes active later in the same event does not change them.
- R10: `sys_rst` stays high while any request is active, and for STRETCH_CYC reference cycles after the last request drops. It then falls on a reference clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Free-running reference clock; all logic runs on it |
| por_n | input | 1 | Asynchronous active-low power-on reset of the controller |
| ext_rst_n | input | 1 | Active-low external reset pin (asynchronous) |
| vmon_above | input | 1 | Supply comparator, 1 = supply above threshold (asynchronous) |
| sys_clk | input | 1 | Monitored system clock |
| bus_sel | input | 1 | Register bus select |
| bus_wr | input | 1 | Register bus write strobe (with bus_sel) |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| sys_rst | output | 1 | Active-high system reset, synchronous to ref_clk |

## Verification
A wrong internal state shows up at `sys_rst` or in the source register within a few reference cycles. A lost or stuck synchronizer stage either drops a reset or keeps it asserted. An off-by-one in the stretch counter moves the falling edge of `sys_rst` by one cycle. A bad priority choice or a mistimed capture leaves the wrong cause bit set on the next read. A timeout counter that is not restarted, or not gated by the enable, shows up as a spurious reset while the clock is running or while the detector is disabled, within TIMEOUT_CYC cycles.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
    localparam logic [7:0] VMON_ADDR = 8'hFF;
    localparam int NSRC      = 3;
    localparam int PIN_BIT   = 0;
    localparam int VMON_BIT  = 1;
    localparam int MCD_BIT   = 2;
    localparam int VEN_BIT   = 7;
    localparam int VSTAT_BIT = 6;
endpackage

// File: rtl/rsc_sync.sv
module rsc_sync #(
    parameter int W = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] s0;
        logic [W-1:0] s1;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d.s0 = d;
        st_d.s1 = st_q.s0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.s0 <= RST_VAL;
            st_q.s1 <= RST_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign q = st_q.s1;
endmodule

// File: rtl/rsc_clk_mon.sv
module rsc_clk_mon #(
    parameter int TIMEOUT_CYC = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sys_clk,
    input  logic en,
    output logic miss
);
    localparam int CW = $clog2(TIMEOUT_CYC + 1);
    localparam logic [CW-1:0] LIM = CW'(TIMEOUT_CYC);

    typedef struct packed {
        logic          prev;
        logic [CW-1:0] cnt;
    } st_t;

    st_t  st_d, st_q;
    logic lvl;

    rsc_sync #(.W(1), .RST_VAL(1'b0)) u_lvl_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (sys_clk),
        .q    (lvl)
    );

    always_comb begin
        st_d      = st_q;
        st_d.prev = lvl;
        if (!en || (lvl != st_q.prev)) begin
            st_d.cnt = '0;
        end else if (st_q.cnt < LIM) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign miss = en && (st_q.cnt >= LIM);
endmodule

// File: rtl/rsc_regs.sv
module rsc_regs #(
    parameter logic [7:0] SRC_ADDR = 8'hEF
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_sel,
    input  logic       bus_wr,
    input  logic [7:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       vstat,
    input  logic [rsc_pkg::NSRC-1:0] flags,
    output logic       ven,
    output logic       vsel,
    output logic       mcd_en
);
    import rsc_pkg::*;

    typedef struct packed {
        logic ven;
        logic vsel;
        logic mcd_en;
    } st_t;

    st_t  st_d, st_q;
    logic wr_v, wr_s;

    assign wr_v = bus_sel && bus_wr && (bus_addr == VMON_ADDR);
    assign wr_s = bus_sel && bus_wr && (bus_addr == SRC_ADDR);

    always_comb begin
        st_d = st_q;
        if (wr_v) begin
            st_d.ven = bus_wdata[VEN_BIT];
        end
        if (wr_s) begin
            st_d.vsel   = bus_wdata[VMON_BIT];
            st_d.mcd_en = bus_wdata[MCD_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == VMON_ADDR) begin
            bus_rdata[VEN_BIT]   = st_q.ven;
            bus_rdata[VSTAT_BIT] = vstat;
        end else if (bus_addr == SRC_ADDR) begin
            bus_rdata[NSRC-1:0] = flags;
        end
    end

    assign ven    = st_q.ven;
    assign vsel   = st_q.vsel;
    assign mcd_en = st_q.mcd_en;
endmodule

// File: rtl/rsc_sequencer.sv
module rsc_sequencer #(
    parameter int STRETCH_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic [rsc_pkg::NSRC-1:0] req,
    output logic req_any,
    output logic sys_rst,
    output logic [rsc_pkg::NSRC-1:0] flags
);
    import rsc_pkg::*;

    localparam int SW = $clog2(STRETCH_CYC + 1);
    localparam logic [SW-1:0] SLOAD = SW'(STRETCH_CYC);

    typedef struct packed {
        logic [SW-1:0]   cnt;
        logic [NSRC-1:0] flags;
    } st_t;

    st_t             st_d, st_q;
    logic [NSRC-1:0] pick;

    // lowest index wins: walk from the weakest source to the strongest
    always_comb begin
        pick = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (req[i]) begin
                pick    = '0;
                pick[i] = 1'b1;
            end
        end
    end

    assign req_any = |req;

    always_comb begin
        st_d = st_q;
        if (req_any) begin
            st_d.cnt = SLOAD;
            if (st_q.cnt == '0) begin
                st_d.flags = pick;
            end
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt   <= SLOAD;
            st_q.flags <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sys_rst = (st_q.cnt != '0);
    assign flags   = st_q.flags;
endmodule

// File: rtl/reset_src_ctrl.sv
module reset_src_ctrl #(
    parameter int TIMEOUT_CYC = 1000,
    parameter int STRETCH_CYC = 16,
    parameter logic [7:0] SRC_ADDR = 8'hEF
) (
    input  logic       ref_clk,
    input  logic       por_n,
    input  logic       ext_rst_n,
    input  logic       vmon_above,
    input  logic       sys_clk,
    input  logic       bus_sel,
    input  logic       bus_wr,
    input  logic [7:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       sys_rst
);
    import rsc_pkg::*;

    logic [1:0]      async_s;
    logic            ext_n_s, above_s;
    logic            ven, vsel, mcd_en, mcd_miss;
    logic            pin_req, vmon_req, req_any;
    logic [NSRC-1:0] req, flags;

    rsc_sync #(.W(2), .RST_VAL(2'b11)) u_in_sync (
        .clk  (ref_clk),
        .rst_n(por_n),
        .d    ({ext_rst_n, vmon_above}),
        .q    (async_s)
    );
    assign ext_n_s = async_s[1];
    assign above_s = async_s[0];

    rsc_clk_mon #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_clk_mon (
        .clk    (ref_clk),
        .rst_n  (por_n),
        .sys_clk(sys_clk),
        .en     (mcd_en),
        .miss   (mcd_miss)
    );

    rsc_regs #(.SRC_ADDR(SRC_ADDR)) u_regs (
        .clk      (ref_clk),
        .rst_n    (por_n),
        .bus_sel  (bus_sel),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .vstat    (above_s),
        .flags    (flags),
        .ven      (ven),
        .vsel     (vsel),
        .mcd_en   (mcd_en)
    );

    assign pin_req  = !ext_n_s;
    assign vmon_req = ven && vsel && !above_s;

    always_comb begin
        req           = '0;
        req[PIN_BIT]  = pin_req;
        req[VMON_BIT] = vmon_req;
        req[MCD_BIT]  = mcd_miss;
    end

    rsc_sequencer #(.STRETCH_CYC(STRETCH_CYC)) u_seq (
        .clk    (ref_clk),
        .rst_n  (por_n),
        .req    (req),
        .req_any(req_any),
        .sys_rst(sys_rst),
        .flags  (flags)
    );
endmodule

// File: rtl/reset_src_ctrl_chk.sv
module reset_src_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_any,
    input logic       sys_rst,
    input logic [2:0] flags,
    input logic       miss,
    input logic       mcd_en,
    input logic       vmon_req,
    input logic       ven,
    input logic       vsel
);
    // R10: any active request holds the system reset on the next edge
    a_r10_req_holds_reset: assert property (@(posedge clk) disable iff (!rst_n)
        req_any |=> sys_rst);

    // R10: release only after a cycle with no request
    a_r10_release_after_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sys_rst) |-> !$past(req_any));

    // R5: the clock detector is silent while disabled
    a_r5_mcd_gated: assert property (@(posedge clk) disable iff (!rst_n)
        miss |-> mcd_en);

    // R7: the supply request needs both enable and select
    a_r7_vmon_gated: assert property (@(posedge clk) disable iff (!rst_n)
        vmon_req |-> (ven && vsel));

    // R8: never more than one cause flag
    a_r8_single_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(flags));

    // R9: flags frozen once a reset event is under way
    a_r9_flags_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst |=> $stable(flags));
endmodule

bind reset_src_ctrl reset_src_ctrl_chk u_chk (
    .clk     (ref_clk),
    .rst_n   (por_n),
    .req_any (req_any),
    .sys_rst (sys_rst),
    .flags   (flags),
    .miss    (mcd_miss),
    .mcd_en  (mcd_en),
    .vmon_req(vmon_req),
    .ven     (ven),
    .vsel    (vsel)
);

// File: tb/reset_src_ctrl_bench.sv
module reset_src_ctrl_bench;
    localparam int TMO  = 64;
    localparam int STR  = 8;
    localparam logic [7:0] SRC = 8'hEF;
    localparam logic [7:0] VMC = 8'hFF;

    logic       ref_clk = 1'b0;
    logic       por_n = 1'b0;
    logic       ext_rst_n = 1'b1;
    logic       vmon_above = 1'b1;
    logic       sys_clk = 1'b0;
    logic       sys_run = 1'b1;
    logic       bus_sel = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       sys_rst;

    int n_chk = 0;
    int n_err = 0;

    reset_src_ctrl #(.TIMEOUT_CYC(TMO), .STRETCH_CYC(STR), .SRC_ADDR(SRC)) u_reset_src_ctrl (
        .ref_clk   (ref_clk),
        .por_n     (por_n),
        .ext_rst_n (ext_rst_n),
        .vmon_above(vmon_above),
        .sys_clk   (sys_clk),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .sys_rst   (sys_rst)
    );

    always #4 ref_clk = ~ref_clk;

    always begin
        #10;
        if (sys_run) sys_clk = ~sys_clk;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge ref_clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge ref_clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge ref_clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge ref_clk);
    endtask

    task automatic wait_release(output int n);
        n = 0;
        while (sys_rst && n < 2000) begin
            @(negedge ref_clk);
            n++;
        end
    endtask

    task automatic chk_release(input string tag);
        int n;
        wait_release(n);
        chk(n >= STR && n <= STR + 6, tag, n, STR);
    endtask

    task automatic t_power_on();
        logic [7:0] d;
        idle(3);
        chk(sys_rst == 1'b1, "R1 reset held during power-on", sys_rst, 1);
        @(negedge ref_clk);
        por_n = 1'b1;
        chk_release("R1 power-on stretch");
        rd(SRC, d);
        chk(d == 8'h00, "R1 source flags clear", d, 8'h00);
        rd(VMC, d);
        chk(d == 8'h40, "R1 supply control reset value", d, 8'h40);
    endtask

    task automatic t_pin();
        logic [7:0] d;
        @(negedge ref_clk);
        ext_rst_n = 1'b0;
        idle(5);
        chk(sys_rst == 1'b1, "R2 pin asserts reset", sys_rst, 1);
        ext_rst_n = 1'b1;
        chk_release("R10 stretch after pin");
        rd(SRC, d);
        chk(d == 8'h01, "R2 pin flag", d, 8'h01);
        chk(d[2] == 1'b0, "R4 clock flag clear after pin reset", d[2], 0);
    endtask

    task automatic t_vmon_reg();
        logic [7:0] d;
        wr(VMC, 8'hFF);
        rd(VMC, d);
        chk(d == 8'hC0, "R6 enable set, low bits ignore writes", d, 8'hC0);
        vmon_above = 1'b0;
        idle(4);
        rd(VMC, d);
        chk(d == 8'h80, "R6 status follows comparator low", d, 8'h80);
        chk(sys_rst == 1'b0, "R7 enabled but unselected gives no reset", sys_rst, 0);
        wr(VMC, 8'h00);
        wr(SRC, 8'h02);
        idle(6);
        chk(sys_rst == 1'b0, "R7 selected but disabled gives no reset", sys_rst, 0);
        vmon_above = 1'b1;
        idle(4);
        rd(VMC, d);
        chk(d == 8'h40, "R6 status follows comparator high", d, 8'h40);
    endtask

    task automatic t_vmon_reset();
        logic [7:0] d;
        wr(VMC, 8'h80);
        wr(SRC, 8'h02);
        @(negedge ref_clk);
        vmon_above = 1'b0;
        idle(5);
        chk(sys_rst == 1'b1, "R7 enabled and selected supply resets", sys_rst, 1);
        vmon_above = 1'b1;
        chk_release("R10 stretch after supply");
        rd(SRC, d);
        chk(d == 8'h02, "R7 supply flag", d, 8'h02);
        chk(d[2] == 1'b0, "R4 clock flag clear after supply reset", d[2], 0);
    endtask

    task automatic t_priority();
        logic [7:0] d;
        @(negedge ref_clk);
        ext_rst_n = 1'b0;
        vmon_above = 1'b0;
        idle(5);
        chk(sys_rst == 1'b1, "R8 combined request resets", sys_rst, 1);
        ext_rst_n = 1'b1;
        vmon_above = 1'b1;
        chk_release("R10 stretch after combined");
        rd(SRC, d);
        chk(d == 8'h01, "R8 pin wins over supply", d, 8'h01);
    endtask

    task automatic t_capture_once();
        logic [7:0] d;
        @(negedge ref_clk);
        ext_rst_n = 1'b0;
        idle(6);
        vmon_above = 1'b0;
        idle(4);
        ext_rst_n = 1'b1;
        idle(STR + 10);
        chk(sys_rst == 1'b1, "R10 held while supply request remains", sys_rst, 1);
        rd(SRC, d);
        chk(d == 8'h01, "R9 flag kept from event start", d, 8'h01);
        vmon_above = 1'b1;
        chk_release("R10 stretch after late request");
        wr(VMC, 8'h00);
    endtask

    task automatic t_clock_stuck(input logic lvl);
        logic [7:0] d;
        wr(SRC, 8'h04);
        idle(TMO + 10);
        chk(sys_rst == 1'b0, "R3 running clock gives no reset", sys_rst, 0);
        wait (sys_clk == lvl);
        sys_run = 1'b0;
        idle(TMO + 20);
        chk(sys_rst == 1'b1, lvl ? "R3 clock stuck high resets" : "R3 clock stuck low resets",
            sys_rst, 1);
        sys_run = 1'b1;
        chk_release("R10 stretch after clock loss");
        rd(SRC, d);
        chk(d == 8'h04, "R3 clock flag", d, 8'h04);
    endtask

    task automatic t_clock_disabled();
        bit seen;
        wr(SRC, 8'h00);
        wait (sys_clk == 1'b0);
        sys_run = 1'b0;
        seen = 1'b0;
        for (int i = 0; i < 3 * TMO; i++) begin
            @(negedge ref_clk);
            if (sys_rst) seen = 1'b1;
        end
        chk(seen == 1'b0, "R5 disabled detector ignores stopped clock", seen, 0);
        wr(SRC, 8'h04);
        idle(TMO + 20);
        chk(sys_rst == 1'b1, "R5 enabling detector on stopped clock resets", sys_rst, 1);
        wr(SRC, 8'h00);
        sys_run = 1'b1;
        chk_release("R10 stretch after disable");
    endtask

    initial begin
        repeat (200000) @(posedge ref_clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        t_power_on();
        t_pin();
        t_vmon_reg();
        t_vmon_reset();
        t_priority();
        t_capture_once();
        t_clock_stuck(1'b1);
        t_clock_stuck(1'b0);
        t_pin();
        t_clock_disabled();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule